// File: doc/BRIEF.md
# Mesh Site Bytecode Actor Engine

This block is one site of a two-dimensional mesh that evaluates a compiled functional program without any central fetch unit. A site is either empty or holds a single actor: a heap object (a number or a pair) or a bytecode (constant, argument or halt). Next to the actor it keeps one continuation record of five 8-bit registers: accumulator, environment, argument-stack pointer, frame pointer and next-free heap address. Control moves through the mesh as continuations handed from a bytecode to its child in the bytecode tree. No site holds a program counter; each bytecode stores its child's heap address, and the next-free address travels inside the continuation.

Each cycle the site looks at its four orthogonal neighbours: whether each exists, what kind of actor it holds and its heap address. It may issue at most one outgoing operation toward one neighbour: hand its continuation to a child bytecode, create a new pair in an empty neighbour, or move its whole actor into an empty neighbour chosen by two pseudorandom bits. The surrounding fabric delivers each issued operation to the addressed neighbour as that neighbour's incoming operation in the same cycle. The outgoing operation is combinational and takes effect at the next clock edge, both in the issuing site and in the receiving site.

Top module: `site_node`

## Requirements
- R1: After reset the site is empty (kind code 0, address 0). It issues no operation (out_op 0, out_dir 0, out_actor 0, out_cont 0), and done and result are 0.
- R2: An incoming place (in_op 2 or 3) into an empty site loads in_actor, packed MSB first as {kind[2:0], self address, field A, field B}, and loads in_cont. The actor starts in ready. Kind codes are 0 empty, 1 number, 2 pair, 3 constant, 4 argument, 5 halt. A place into an occupied site changes nothing.
- R3: An incoming hand-off (in_op 1) to a site holding a bytecode loads in_cont and forces the actor into locked, whatever its state. A hand-off to an empty site or to a heap object is ignored, and that object's continuation stays unchanged.
- R4: A constant in locked loads its accumulator with its operand (field B) at the next edge and enters continue.
- R5: In continue, the site issues a hand-off (out_op 1) with its full continuation on out_cont, packed MSB first as {acc, env, args, frame, next-free}. It targets the lowest-numbered direction (0 north, 1 east, 2 south, 3 west) whose neighbour is present and stores the child address held in field A. The site then returns to ready. While no neighbour matches it waits, and a missing neighbour never matches.
- R6: An argument in locked enters put at the next edge. In put it waits for a present empty neighbour, then issues an allocation (out_op 2) to the lowest-numbered such direction with out_actor {pair, next-free, acc, args} and out_cont 0. At the same edge args takes the old next-free value, next-free increments modulo 256, and the state becomes continue.
- R7: A halt that has received a continuation raises done and presents its accumulator on result. It keeps both for as long as it holds the continuation and never moves.
- R8: A non-empty site in ready, with no incoming operation, issues a move (out_op 3) toward direction rnd when that neighbour is present and empty. The move carries the whole actor and continuation, and the site is empty at the next edge. A site in locked, continue or put never moves.
- R9: In any cycle with a non-zero in_op the site issues no outgoing operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Site clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rnd | input | 2 | Pseudorandom direction for diffusion |
| nb_present | input | 4 | Neighbour exists, one bit per direction |
| nb_kind | input | 12 | Neighbour actor kind, 3 bits per direction, direction 0 in the low bits |
| nb_addr | input | 32 | Neighbour heap address, 8 bits per direction, direction 0 in the low bits |
| in_op | input | 2 | Incoming operation: 0 none, 1 hand-off, 2 or 3 place |
| in_actor | input | 27 | Actor being placed |
| in_cont | input | 40 | Continuation being delivered |
| out_op | output | 2 | Outgoing operation: 0 none, 1 hand-off, 2 allocate pair, 3 move |
| out_dir | output | 2 | Target direction of the outgoing operation |
| out_actor | output | 27 | Actor sent with an allocation or move |
| out_cont | output | 40 | Continuation sent with a hand-off or move |
| site_kind | output | 3 | Kind of the actor held here |
| site_addr | output | 8 | Heap address of the actor held here |
| done | output | 1 | Halt has received a continuation |
| result | output | 8 | Accumulator of the finished continuation, 0 otherwise |

## Verification
The bench steers continue-state sites past an absent neighbour that carries the child's address, and past several matching neighbours. A scan that trusts absent sites, or that picks a higher direction first, would hand the continuation to a phantom or wrong cell. In put, the allocation must wait while every neighbour is full, and the next-free register is started at 255 so that a missing wrap or a stale argument-stack pointer shows up in the following hand-off. Incoming operations are applied in the same cycle a move or hand-off would go out, hand-offs are sent to heap objects, and places are sent into occupied sites. A design that lets two operations through, locks a number or overwrites a resident actor would leak or duplicate an actor.

// File: rtl/site_pkg.sv
package site_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [2:0] {
      K_EMPTY = 3'd0,
      K_NUM   = 3'd1,
      K_PAIR  = 3'd2,
      K_CONST = 3'd3,
      K_ARG   = 3'd4,
      K_HALT  = 3'd5
   } kind_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_HAND  = 2'd1,
      OP_ALLOC = 2'd2,
      OP_MOVE  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ST_READY  = 2'd0,
      ST_LOCKED = 2'd1,
      ST_CONT   = 2'd2,
      ST_PUT    = 2'd3
   } st_e;

   function automatic logic is_code(input logic [KIND_W-1:0] k);
      return (k == K_CONST) || (k == K_ARG) || (k == K_HALT);
   endfunction
endpackage

// File: rtl/site_scan.sv
module site_scan
   import site_pkg::*;
#(
   parameter int AW   = 8,
   parameter int NDIR = 4
) (
   input  logic [NDIR-1:0]        nb_present,
   input  logic [NDIR*KIND_W-1:0] nb_kind,
   input  logic [NDIR*AW-1:0]     nb_addr,
   input  logic [AW-1:0]          child,
   output logic                   child_hit,
   output logic [$clog2(NDIR)-1:0] child_dir,
   output logic                   free_hit,
   output logic [$clog2(NDIR)-1:0] free_dir
);
   localparam int DIR_W = $clog2(NDIR);

   logic [NDIR-1:0] hit_v;
   logic [NDIR-1:0] free_v;

   for (genvar i = 0; i < NDIR; i++) begin : g_dir
      assign hit_v[i]  = nb_present[i] && (nb_addr[i*AW +: AW] == child);
      assign free_v[i] = nb_present[i] && (nb_kind[i*KIND_W +: KIND_W] == K_EMPTY);
   end

   always_comb begin
      child_dir = '0;
      free_dir  = '0;
      for (int i = NDIR - 1; i >= 0; i--) begin
         if (hit_v[i])  child_dir = DIR_W'(i);
         if (free_v[i]) free_dir  = DIR_W'(i);
      end
   end

   assign child_hit = |hit_v;
   assign free_hit  = |free_v;

   // R5: a reported child always sits in a present neighbour carrying the address
   always_comb begin
      if (child_hit) begin
         a_r5_hit_is_real: assert (nb_present[child_dir] &&
                                   nb_addr[child_dir*AW +: AW] == child);
      end
   end
endmodule

// File: rtl/site_diffuse.sv
module site_diffuse
   import site_pkg::*;
#(
   parameter int NDIR = 4
) (
   input  logic [NDIR-1:0]         nb_present,
   input  logic [NDIR*KIND_W-1:0]  nb_kind,
   input  logic [$clog2(NDIR)-1:0] rnd,
   output logic                    move_ok,
   output logic [$clog2(NDIR)-1:0] move_dir
);
   assign move_dir = rnd;
   assign move_ok  = nb_present[rnd] && (nb_kind[rnd*KIND_W +: KIND_W] == K_EMPTY);
endmodule

// File: rtl/site_core.sv
module site_core
   import site_pkg::*;
#(
   parameter int AW   = 8,
   parameter int NDIR = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              in_op,
   input  logic [KIND_W+3*AW-1:0]  in_actor,
   input  logic [5*AW-1:0]         in_cont,
   input  logic                    child_hit,
   input  logic [$clog2(NDIR)-1:0] child_dir,
   input  logic                    free_hit,
   input  logic [$clog2(NDIR)-1:0] free_dir,
   input  logic                    move_ok,
   input  logic [$clog2(NDIR)-1:0] move_dir,
   output logic [AW-1:0]           child,
   output logic [1:0]              out_op,
   output logic [$clog2(NDIR)-1:0] out_dir,
   output logic [KIND_W+3*AW-1:0]  out_actor,
   output logic [5*AW-1:0]         out_cont,
   output logic [KIND_W-1:0]       site_kind,
   output logic [AW-1:0]           site_addr,
   output logic                    done,
   output logic [AW-1:0]           result
);
   localparam int DIR_W  = $clog2(NDIR);
   localparam int ACT_W  = KIND_W + 3*AW;
   localparam int CONT_W = 5*AW;

   logic [KIND_W-1:0] kind_q;
   logic [AW-1:0]     self_q, fa_q, fb_q;
   logic [AW-1:0]     acc_q, env_q, args_q, frm_q, nfa_q;
   st_e               st_q;

   op_e               op_n;
   logic [DIR_W-1:0]  dir_n;
   logic [ACT_W-1:0]  act_n;
   logic [CONT_W-1:0] cont_n;
   logic              quiet;
   logic [CONT_W-1:0] cont_now;

   assign quiet    = (in_op == OP_NONE);
   assign cont_now = {acc_q, env_q, args_q, frm_q, nfa_q};

   always_comb begin
      op_n   = OP_NONE;
      dir_n  = '0;
      act_n  = '0;
      cont_n = '0;
      if (quiet) begin
         unique case (st_q)
            ST_CONT: if (child_hit) begin
               op_n   = OP_HAND;
               dir_n  = child_dir;
               cont_n = cont_now;
            end
            ST_PUT: if (free_hit) begin
               op_n  = OP_ALLOC;
               dir_n = free_dir;
               act_n = {K_PAIR, nfa_q, acc_q, args_q};
            end
            ST_READY: if (kind_q != K_EMPTY && move_ok) begin
               op_n   = OP_MOVE;
               dir_n  = move_dir;
               act_n  = {kind_q, self_q, fa_q, fb_q};
               cont_n = cont_now;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= K_EMPTY;
         self_q <= '0; fa_q <= '0; fb_q <= '0;
         acc_q  <= '0; env_q <= '0; args_q <= '0; frm_q <= '0; nfa_q <= '0;
         st_q   <= ST_READY;
      end else if (in_op == OP_HAND) begin
         if (is_code(kind_q)) begin
            {acc_q, env_q, args_q, frm_q, nfa_q} <= in_cont;
            st_q <= ST_LOCKED;
         end
      end else if (!quiet) begin
         if (kind_q == K_EMPTY) begin
            {kind_q, self_q, fa_q, fb_q}         <= in_actor;
            {acc_q, env_q, args_q, frm_q, nfa_q} <= in_cont;
            st_q <= ST_READY;
         end
      end else begin
         unique case (op_n)
            OP_MOVE: begin
               kind_q <= K_EMPTY;
               self_q <= '0; fa_q <= '0; fb_q <= '0;
               acc_q  <= '0; env_q <= '0; args_q <= '0; frm_q <= '0; nfa_q <= '0;
            end
            OP_HAND:  st_q <= ST_READY;
            OP_ALLOC: begin
               args_q <= nfa_q;
               nfa_q  <= nfa_q + AW'(1);
               st_q   <= ST_CONT;
            end
            default: if (st_q == ST_LOCKED) begin
               if (kind_q == K_CONST) begin
                  acc_q <= fb_q;
                  st_q  <= ST_CONT;
               end else if (kind_q == K_ARG) begin
                  st_q  <= ST_PUT;
               end
            end
         endcase
      end
   end

   assign child     = fa_q;
   assign out_op    = op_n;
   assign out_dir   = dir_n;
   assign out_actor = act_n;
   assign out_cont  = cont_n;
   assign site_kind = kind_q;
   assign site_addr = self_q;
   assign done      = (kind_q == K_HALT) && (st_q == ST_LOCKED);
   assign result    = done ? acc_q : '0;

   a_r3_lock_on_hand: assert property (@(posedge clk) disable iff (!rst_n)
      (in_op == OP_HAND && is_code(kind_q)) |=> (st_q == ST_LOCKED));

   a_r4_const_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && st_q == ST_LOCKED && kind_q == K_CONST) |=> (acc_q == $past(fb_q)));

   a_r6_nfa_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_op == OP_ALLOC) |=> (nfa_q == $past(nfa_q) + 1'b1 && args_q == $past(nfa_q)));

   a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   a_r8_move_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (out_op == OP_MOVE) |=> (kind_q == K_EMPTY));
endmodule

// File: rtl/site_node.sv
module site_node
   import site_pkg::*;
#(
   parameter int AW   = 8,
   parameter int NDIR = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(NDIR)-1:0] rnd,
   input  logic [NDIR-1:0]         nb_present,
   input  logic [NDIR*3-1:0]       nb_kind,
   input  logic [NDIR*AW-1:0]      nb_addr,
   input  logic [1:0]              in_op,
   input  logic [3+3*AW-1:0]       in_actor,
   input  logic [5*AW-1:0]         in_cont,
   output logic [1:0]              out_op,
   output logic [$clog2(NDIR)-1:0] out_dir,
   output logic [3+3*AW-1:0]       out_actor,
   output logic [5*AW-1:0]         out_cont,
   output logic [2:0]              site_kind,
   output logic [AW-1:0]           site_addr,
   output logic                    done,
   output logic [AW-1:0]           result
);
   localparam int DIR_W = $clog2(NDIR);

   if (NDIR < 2 || (1 << DIR_W) != NDIR) begin : g_bad_ndir
      $error("site_node: NDIR must be a power of two of at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("site_node: AW must be at least 2");
   end

   logic [AW-1:0]    child;
   logic             child_hit, free_hit, move_ok;
   logic [DIR_W-1:0] child_dir, free_dir, move_dir;

   site_scan #(.AW(AW), .NDIR(NDIR)) u_scan (
      .nb_present (nb_present),
      .nb_kind    (nb_kind),
      .nb_addr    (nb_addr),
      .child      (child),
      .child_hit  (child_hit),
      .child_dir  (child_dir),
      .free_hit   (free_hit),
      .free_dir   (free_dir)
   );

   site_diffuse #(.NDIR(NDIR)) u_diffuse (
      .nb_present (nb_present),
      .nb_kind    (nb_kind),
      .rnd        (rnd),
      .move_ok    (move_ok),
      .move_dir   (move_dir)
   );

   site_core #(.AW(AW), .NDIR(NDIR)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_op      (in_op),
      .in_actor   (in_actor),
      .in_cont    (in_cont),
      .child_hit  (child_hit),
      .child_dir  (child_dir),
      .free_hit   (free_hit),
      .free_dir   (free_dir),
      .move_ok    (move_ok),
      .move_dir   (move_dir),
      .child      (child),
      .out_op     (out_op),
      .out_dir    (out_dir),
      .out_actor  (out_actor),
      .out_cont   (out_cont),
      .site_kind  (site_kind),
      .site_addr  (site_addr),
      .done       (done),
      .result     (result)
   );

   a_r6_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
      (out_op == OP_ALLOC) |-> (nb_present[out_dir] &&
                                nb_kind[out_dir*3 +: 3] == K_EMPTY));

   a_r8_move_follows_rnd: assert property (@(posedge clk) disable iff (!rst_n)
      (out_op == OP_MOVE) |-> (out_dir == rnd && nb_present[rnd] &&
                               nb_kind[rnd*3 +: 3] == K_EMPTY));

   a_r9_one_op_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      (in_op != OP_NONE) |-> (out_op == OP_NONE));
endmodule

// File: tb/site_node_tb.sv
`timescale 1ns/1ps
module site_node_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rnd = '0;
   logic [3:0]  nb_present = '0;
   logic [11:0] nb_kind = '0;
   logic [31:0] nb_addr = '0;
   logic [1:0]  in_op = '0;
   logic [26:0] in_actor = '0;
   logic [39:0] in_cont = '0;
   logic [1:0]  out_op, out_dir;
   logic [26:0] out_actor;
   logic [39:0] out_cont;
   logic [2:0]  site_kind;
   logic [7:0]  site_addr, result;
   logic        done;

   int n_checks = 0;
   int n_fail   = 0;

   // reference model state: st 0 ready, 1 locked, 2 continue, 3 put
   int m_kind, m_self, m_a, m_b, m_acc, m_env, m_args, m_frm, m_nfa, m_st;
   int e_op, e_dir;
   logic [26:0] e_act;
   logic [39:0] e_cont;

   always #2 clk = ~clk;

   site_node u_dut (
      .clk(clk), .rst_n(rst_n), .rnd(rnd), .nb_present(nb_present),
      .nb_kind(nb_kind), .nb_addr(nb_addr), .in_op(in_op),
      .in_actor(in_actor), .in_cont(in_cont), .out_op(out_op),
      .out_dir(out_dir), .out_actor(out_actor), .out_cont(out_cont),
      .site_kind(site_kind), .site_addr(site_addr), .done(done),
      .result(result)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      m_kind = 0; m_self = 0; m_a = 0; m_b = 0;
      m_acc = 0; m_env = 0; m_args = 0; m_frm = 0; m_nfa = 0; m_st = 0;
   endtask

   function automatic logic [39:0] m_cont();
      return {m_acc[7:0], m_env[7:0], m_args[7:0], m_frm[7:0], m_nfa[7:0]};
   endfunction

   task automatic model_expect();
      int hit;
      e_op = 0; e_dir = 0; e_act = '0; e_cont = '0;
      if (in_op != 0) return;
      if (m_st == 2) begin
         hit = -1;
         for (int d = 3; d >= 0; d--)
            if (nb_present[d] && nb_addr[d*8 +: 8] == m_a[7:0]) hit = d;
         if (hit >= 0) begin e_op = 1; e_dir = hit; e_cont = m_cont(); end
      end else if (m_st == 3) begin
         hit = -1;
         for (int d = 3; d >= 0; d--)
            if (nb_present[d] && nb_kind[d*3 +: 3] == 3'd0) hit = d;
         if (hit >= 0) begin
            e_op = 2; e_dir = hit;
            e_act = {3'd2, m_nfa[7:0], m_acc[7:0], m_args[7:0]};
         end
      end else if (m_st == 0 && m_kind != 0 && nb_present[rnd] &&
                   nb_kind[rnd*3 +: 3] == 3'd0) begin
         e_op = 3; e_dir = int'(rnd);
         e_act = {m_kind[2:0], m_self[7:0], m_a[7:0], m_b[7:0]};
         e_cont = m_cont();
      end
   endtask

   task automatic model_step();
      if (in_op == 1) begin
         if (m_kind >= 3) begin
            {m_acc[7:0], m_env[7:0], m_args[7:0], m_frm[7:0], m_nfa[7:0]} = in_cont;
            m_st = 1;
         end
      end else if (in_op >= 2) begin
         if (m_kind == 0) begin
            m_kind = int'(in_actor[26:24]); m_self = int'(in_actor[23:16]);
            m_a = int'(in_actor[15:8]);     m_b = int'(in_actor[7:0]);
            m_acc = int'(in_cont[39:32]); m_env = int'(in_cont[31:24]);
            m_args = int'(in_cont[23:16]); m_frm = int'(in_cont[15:8]);
            m_nfa = int'(in_cont[7:0]); m_st = 0;
         end
      end else if (e_op == 3) model_clear();
      else if (e_op == 1) m_st = 0;
      else if (e_op == 2) begin m_args = m_nfa; m_nfa = (m_nfa + 1) % 256; m_st = 2; end
      else if (m_st == 1) begin
         if (m_kind == 3) begin m_acc = m_b; m_st = 2; end
         else if (m_kind == 4) m_st = 3;
      end
   endtask

   // settle, then compare every output against the model
   task automatic look(input string tag);
      #1;
      model_expect();
      chk(tag, "out_op", out_op, e_op);
      chk(tag, "out_dir", out_dir, e_dir);
      chk(tag, "out_actor", out_actor, e_act);
      chk(tag, "out_cont", out_cont, e_cont);
      chk(tag, "site_kind", site_kind, m_kind);
      chk(tag, "site_addr", site_addr, m_self);
      chk(tag, "done", done, (m_kind == 5 && m_st == 1));
      chk(tag, "result", result, (m_kind == 5 && m_st == 1) ? m_acc : 0);
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      in_op = 0;
   endtask

   task automatic set_nb(input int d, input bit p, input int k, input int a);
      nb_present[d] = p;
      nb_kind[d*3 +: 3] = k[2:0];
      nb_addr[d*8 +: 8] = a[7:0];
   endtask

   task automatic clear_nb();
      nb_present = '0; nb_kind = '0; nb_addr = '0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_clear();
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      model_clear();
      do_reset();
      look("R1");
      chk("R1", "site_kind", site_kind, 0);
      tick();

      // constant bytecode: self 10, child 11, operand 40
      in_op = 2; in_actor = {3'd3, 8'd10, 8'd11, 8'd40}; in_cont = '0;
      look("R2"); tick();
      in_op = 2; in_actor = {3'd1, 8'd77, 8'd0, 8'd0};
      look("R2"); tick();
      chk("R2", "site_addr kept", site_addr, 10);
      in_op = 1; in_cont = {8'd1, 8'd2, 8'd3, 8'd4, 8'd50};
      look("R3"); tick();
      look("R4"); tick();
      set_nb(0, 0, 3, 11);
      set_nb(1, 1, 3, 12);
      look("R5"); tick();
      look("R5"); tick();
      set_nb(2, 1, 3, 11);
      set_nb(3, 1, 3, 11);
      look("R5");
      chk("R5", "hand dir", out_dir, 2);
      chk("R5", "hand cont", out_cont, {8'd40, 8'd2, 8'd3, 8'd4, 8'd50});
      tick();
      clear_nb(); set_nb(1, 1, 0, 0); rnd = 2'd1;
      look("R8");
      chk("R8", "move op", out_op, 3);
      tick();
      look("R8");
      tick();

      // number ignores a hand-off
      clear_nb();
      in_op = 2; in_actor = {3'd1, 8'd60, 8'd0, 8'd0}; in_cont = '0;
      look("R2"); tick();
      in_op = 1; in_cont = {5{8'd9}};
      look("R3"); tick();
      set_nb(1, 1, 0, 0);
      look("R3");
      chk("R3", "number cont untouched", out_cont, 0);
      tick();

      // argument bytecode: self 20, child 21, next-free 255
      clear_nb();
      in_op = 2; in_actor = {3'd4, 8'd20, 8'd21, 8'd0}; in_cont = '0;
      look("R2"); tick();
      in_op = 1; in_cont = {8'd7, 8'd0, 8'd9, 8'd0, 8'd255};
      look("R3"); tick();
      look("R6"); tick();
      set_nb(0, 1, 1, 5);
      look("R6"); tick();
      set_nb(2, 1, 0, 0);
      set_nb(3, 1, 0, 0);
      look("R6");
      chk("R6", "alloc op", out_op, 2);
      chk("R6", "alloc dir", out_dir, 2);
      chk("R6", "alloc pair", out_actor, {3'd2, 8'd255, 8'd7, 8'd9});
      tick();
      set_nb(2, 1, 1, 1); set_nb(3, 1, 1, 2);
      set_nb(0, 1, 4, 21);
      in_op = 2; in_actor = {3'd1, 8'd3, 8'd0, 8'd0};
      look("R9");
      chk("R9", "no op on input", out_op, 0);
      tick();
      look("R6");
      chk("R6", "wrapped cont", out_cont, {8'd7, 8'd0, 8'd255, 8'd0, 8'd0});
      tick();
      set_nb(0, 1, 1, 5); set_nb(2, 1, 0, 0); rnd = 2'd3;
      look("R8"); tick();
      rnd = 2'd2; in_op = 1; in_cont = {8'd5, 8'd0, 8'd0, 8'd0, 8'd1};
      look("R9");
      chk("R9", "move held back", out_op, 0);
      tick();

      // mixed neighbour patterns
      lf = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
         lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
         nb_present = lf[3:0];
         nb_kind = {lf[11:9] % 3'd6, lf[8:6] % 3'd6, lf[5:3] % 3'd6, lf[2:0] % 3'd6};
         nb_addr = {(lf[12] ? 8'd21 : 8'd5), (lf[13] ? 8'd11 : 8'd20),
                    (lf[14] ? 8'd21 : 8'd11), (lf[15] ? 8'd11 : 8'd5)};
         rnd = lf[7:6];
         in_op = (lf[10:8] == 3'd0) ? 2'd1 : (lf[10:8] == 3'd1) ? 2'd2 : 2'd0;
         in_actor = {(lf[2:0] % 3'd5) + 3'd1, lf[15:8], (lf[4] ? 8'd11 : 8'd21), lf[7:0]};
         in_cont = {lf, lf, lf[7:0]};
         look("R8"); tick();
      end

      // halt bytecode
      do_reset();
      clear_nb();
      in_op = 2; in_actor = {3'd5, 8'd30, 8'd0, 8'd0}; in_cont = '0;
      look("R2"); tick();
      in_op = 1; in_cont = {8'd99, 8'd1, 8'd1, 8'd1, 8'd1};
      look("R3"); tick();
      look("R7");
      chk("R7", "done", done, 1);
      chk("R7", "result", result, 99);
      set_nb(1, 1, 0, 0); rnd = 2'd1;
      look("R8");
      chk("R8", "halt stays", out_op, 0);
      tick();
      look("R7");
      chk("R7", "done held", done, 1);
      tick();

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule